// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a 32-bit virtual address to a 30-bit physical address through a four-entry table of segments held in internal registers. The top two address bits pick an entry. The remaining 30 bits form an offset. The offset is compared against that entry's limit. If the offset is within the limit, it is added to the entry's physical base. If the offset is over the limit, or the entry is not marked valid, the block returns a fault flag and no address.

Software fills the table through a one-cycle write strobe. Each write carries an index, a base, a limit and a valid bit. Lookups arrive on a valid/ready request channel. Each result comes back one cycle later on a registered valid/ready response channel. While the response is stalled, the block holds the result and refuses new requests.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every table entry is invalid. A lookup to any segment then returns `rsp_fault`=1.
- R2: `req_vaddr[31:30]` selects the table entry, and `req_vaddr[29:0]` is the offset.
- R3: For a valid entry whose offset does not exceed the limit, `rsp_paddr` = (base + offset) modulo 2^30, and `rsp_fault` = 0.
- R4: An offset equal to the entry's limit is in range, so the limit is inclusive.
- R5: An offset greater than the entry's limit gives `rsp_fault`=1 with `rsp_paddr`=0.
- R6: A lookup to an entry whose valid bit is 0 gives `rsp_fault`=1 with `rsp_paddr`=0.
- R7: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) shows its result with `rsp_valid`=1 after that same edge. This is a latency of one cycle.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and the response fields stay unchanged. Once `rsp_ready` returns to 1, `req_ready` is 1 in the same cycle.
- R9: A table write in the same cycle as an accepted lookup to that entry does not affect that lookup. Lookups from the next cycle on see the new entry.
- R10: A table write with `cfg_valid`=0 marks the entry invalid, and later lookups to it fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 2 | Entry index to write |
| cfg_base | input | 30 | Physical base for the entry |
| cfg_limit | input | 30 | Largest legal offset for the entry |
| cfg_valid | input | 1 | Valid bit stored with the entry |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_vaddr | input | 32 | Virtual address: segment in [31:30], offset in [29:0] |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 30 | Translated physical address, 0 on fault |
| rsp_fault | output | 1 | Limit or invalid-entry fault |

## Verification
Lookups are made to three entries with different bases: a zero base, a mid-range base and a base near the top of memory. A mismatch in any of them shows whether the segment bits and the add are wired correctly, and the near-top base shows the modulo wrap. For each entry, the offsets used are zero, an in-range value, the exact limit and the limit plus one. These tell an inclusive comparison apart from an exclusive one. Further lookups go to never-written and cleared entries, to an entry written in the same cycle, and to requests made while the response is held back. These separate the valid-bit, write-timing and stall-holding behaviours.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned VA_W_DEF     = 32;
  localparam int unsigned PA_W_DEF     = 30;
  localparam int unsigned SEG_BITS_DEF = 2;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int unsigned SEG_BITS = 2,
  parameter int unsigned PA_W     = 30,
  parameter int unsigned OFF_W    = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEG_BITS-1:0] wr_idx,
  input  logic [PA_W-1:0]     wr_base,
  input  logic [OFF_W-1:0]    wr_limit,
  input  logic                wr_vld,
  input  logic [SEG_BITS-1:0] rd_idx,
  output logic [PA_W-1:0]     rd_base,
  output logic [OFF_W-1:0]    rd_limit,
  output logic                rd_vld
);
  localparam int unsigned NSEG = 1 << SEG_BITS;

  logic [PA_W-1:0]  base_q  [NSEG];
  logic [OFF_W-1:0] limit_q [NSEG];
  logic [NSEG-1:0]  vld_q, vld_d;
  logic [NSEG-1:0]  ent_en;

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    assign ent_en[g] = wr_en && (wr_idx == SEG_BITS'(g));

    always_ff @(posedge clk) begin
      if (ent_en[g]) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
      end
    end

    always_comb begin
      vld_d[g] = vld_q[g];
      if (ent_en[g]) vld_d[g] = wr_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_limit = limit_q[rd_idx];
  assign rd_vld   = vld_q[rd_idx];

  // R10: a write stores exactly the valid bit it carried
  assert_wr_vld_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_idx)] == $past(wr_vld)));
endmodule

// File: rtl/seg_check_add.sv
module seg_check_add #(
  parameter int unsigned PA_W  = 30,
  parameter int unsigned OFF_W = 30
) (
  input  logic [PA_W-1:0]  base,
  input  logic [OFF_W-1:0] limit,
  input  logic             vld,
  input  logic [OFF_W-1:0] offset,
  output logic [PA_W-1:0]  paddr,
  output logic             fault
);
  logic [PA_W-1:0] sum;
  logic            over;

  always_comb begin
    sum   = base + PA_W'(offset);
    over  = offset > limit;
    fault = !vld || over;
    paddr = fault ? '0 : sum;
  end
endmodule

// File: rtl/xlate_rsp_reg.sv
module xlate_rsp_reg #(
  parameter int unsigned PA_W = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            take,
  input  logic [PA_W-1:0] d_paddr,
  input  logic            d_fault,
  output logic            q_valid,
  output logic [PA_W-1:0] q_paddr,
  output logic            q_fault
);
  logic valid_d;

  always_comb begin
    valid_d = q_valid;
    if (take)  valid_d = 1'b0;
    if (load)  valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q_paddr <= d_paddr;
      q_fault <= d_fault;
    end
  end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W     = VA_W_DEF,
  parameter int unsigned PA_W     = PA_W_DEF,
  parameter int unsigned SEG_BITS = SEG_BITS_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [SEG_BITS-1:0]      cfg_idx,
  input  logic [PA_W-1:0]          cfg_base,
  input  logic [VA_W-SEG_BITS-1:0] cfg_limit,
  input  logic                     cfg_valid,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_vaddr,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [PA_W-1:0]          rsp_paddr,
  output logic                     rsp_fault
);
  localparam int unsigned OFF_W = VA_W - SEG_BITS;

  logic [SEG_BITS-1:0] seg;
  logic [OFF_W-1:0]    offset;
  logic [PA_W-1:0]     ent_base;
  logic [OFF_W-1:0]    ent_limit;
  logic                ent_vld;
  logic [PA_W-1:0]     xl_paddr;
  logic                xl_fault;
  logic                accept;

  assign seg       = req_vaddr[VA_W-1 -: SEG_BITS];
  assign offset    = req_vaddr[OFF_W-1:0];
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  seg_table #(.SEG_BITS(SEG_BITS), .PA_W(PA_W), .OFF_W(OFF_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_base(cfg_base),
    .wr_limit(cfg_limit), .wr_vld(cfg_valid),
    .rd_idx(seg), .rd_base(ent_base), .rd_limit(ent_limit), .rd_vld(ent_vld)
  );

  seg_check_add #(.PA_W(PA_W), .OFF_W(OFF_W)) u_check (
    .base(ent_base), .limit(ent_limit), .vld(ent_vld), .offset(offset),
    .paddr(xl_paddr), .fault(xl_fault)
  );

  xlate_rsp_reg #(.PA_W(PA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .take(rsp_valid && rsp_ready),
    .d_paddr(xl_paddr), .d_fault(xl_fault),
    .q_valid(rsp_valid), .q_paddr(rsp_paddr), .q_fault(rsp_fault)
  );

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  assert_stall_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  assert_invalid_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ent_vld) |=> rsp_fault);
endmodule

// File: tb/tb_seg_xlate_top.sv
`timescale 1ns/1ps
module tb_seg_xlate_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_valid;
  logic [1:0]  cfg_idx;
  logic [29:0] cfg_base, cfg_limit;
  logic        req_valid, req_ready, rsp_valid, rsp_ready, rsp_fault;
  logic [31:0] req_vaddr;
  logic [29:0] rsp_paddr;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  seg_xlate_top dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .cfg_valid(cfg_valid),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_seg(input logic [1:0] idx, input logic [29:0] base,
                           input logic [29:0] limit, input logic vld);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_base = base; cfg_limit = limit; cfg_valid = vld;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one lookup with the consumer always ready; checks latency and result
  task automatic lookup(input string req, input logic [1:0] seg, input logic [29:0] off,
                        input logic [29:0] exp_pa, input logic exp_fault);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {seg, off}; rsp_ready = 1'b1;
    chk({req, " ready"}, {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " R7 valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({req, " fault"}, {31'd0, rsp_fault}, {31'd0, exp_fault});
    chk({req, " paddr"}, {2'd0, rsp_paddr}, {2'd0, exp_pa});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cfg_we = 0; cfg_idx = 0; cfg_base = 0; cfg_limit = 0; cfg_valid = 0;
    req_valid = 0; req_vaddr = 0; rsp_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    lookup("R1 seg0 unwritten", 2'd0, 30'h10, 30'h0, 1'b1);
    lookup("R6 seg3 unwritten", 2'd3, 30'h0, 30'h0, 1'b1);
  endtask

  task automatic t_load;
    write_seg(2'd0, 30'h4000, 30'h700, 1'b1);
    write_seg(2'd1, 30'h0, 30'h500, 1'b1);
    write_seg(2'd2, 30'h2000, 30'h1000, 1'b1);
  endtask

  task automatic t_translate;
    lookup("R3 seg2 mid", 2'd2, 30'h200, 30'h2200, 1'b0);
    lookup("R2 seg0 zero", 2'd0, 30'h0, 30'h4000, 1'b0);
    lookup("R2 seg1 mid", 2'd1, 30'h123, 30'h123, 1'b0);
    lookup("R4 seg0 at limit", 2'd0, 30'h700, 30'h4700, 1'b0);
    lookup("R4 seg2 at limit", 2'd2, 30'h1000, 30'h3000, 1'b0);
    lookup("R5 seg0 over", 2'd0, 30'h701, 30'h0, 1'b1);
    lookup("R5 seg1 far over", 2'd1, 30'h3FFF_FFFF, 30'h0, 1'b1);
  endtask

  task automatic t_same_cycle;
    // R9: seg3 written in the lookup's cycle; that lookup still sees invalid
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd3; cfg_base = 30'h3FFF_F000; cfg_limit = 30'h3FFF_FFFF; cfg_valid = 1'b1;
    req_valid = 1'b1; req_vaddr = {2'd3, 30'h2000}; rsp_ready = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R9 same-cycle fault", {31'd0, rsp_fault}, 32'd1);
    lookup("R9 next lookup, R3 wrap", 2'd3, 30'h2000, 30'h1000, 1'b0);
  endtask

  task automatic t_invalidate;
    write_seg(2'd1, 30'h0, 30'h500, 1'b0);
    lookup("R10 cleared seg1", 2'd1, 30'h10, 30'h0, 1'b1);
    lookup("R10 seg2 untouched", 2'd2, 30'h10, 30'h2010, 1'b0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_vaddr = {2'd2, 30'h40};
    @(negedge clk);
    req_vaddr = {2'd0, 30'h5};
    chk("R8 valid in stall", {31'd0, rsp_valid}, 32'd1);
    chk("R8 ready low", {31'd0, req_ready}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R8 held paddr", {2'd0, rsp_paddr}, 32'h2040);
    chk("R8 held fault", {31'd0, rsp_fault}, 32'd0);
    chk("R8 ready still low", {31'd0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    #1;
    chk("R8 ready on release", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 second result", {2'd0, rsp_paddr}, 32'h4005);
    @(negedge clk);
    chk("R8 drained", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_translate();
    t_same_cycle();
    t_invalidate();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule